// File: doc/BRIEF.md
# Write-Triggered Quick DMA Channel Unit

This block starts quick DMA channels without a dedicated start bit. Each channel has a map register that names one parameter set and one word inside that set. The unit watches the write strobe and byte address going into the parameter memory. When that memory is written at the mapped word of the mapped set, and the channel is enabled, the channel raises an event. A fixed-priority arbiter offers pending events to the transfer engine, lowest channel first.

Software programs the unit through a small word-addressed register port. It has map registers, enable set and clear registers, and event, secondary-event and missed-event registers, each with a write-one-to-clear partner. Once the engine takes a grant, the event moves into the secondary register, which marks the transfer as in flight. A trigger that arrives while an event or secondary event is still pending sets the missed bit and is not queued. To stop a channel, software clears its enable, clears its secondary and missed bits, and writes zero to its map.

Top module: `qdma_trig_unit`

## Requirements
- R1: Map register n sits at word offset n (0 to 7). Its set number is in bits 13:5 and its trigger word index is in bits 4:2. A readback returns only those two fields, with every other bit zero.
- R2: A parameter-memory write whose byte address equals set*32 + word*4 for an enabled channel, with no event or secondary event pending on it, sets that channel's bit in `evt_req` one cycle later.
- R3: A matching parameter-memory write on a channel whose enable bit is clear has no effect on `evt_req`.
- R4: Writing to enable-set (offset 9) sets the enable bits where the data holds ones. Writing to enable-clear (offset 10) clears them. Zero bits have no effect. The enable bits read back at offset 8.
- R5: A write to another word of the mapped set, or to the same word of another set, does not trigger the channel. Neither does the mapped address when the write strobe is low.
- R6: A trigger on a channel whose event bit or secondary bit is already set sets that channel's missed bit, which reads back at offset 15. The event is not queued, so `evt_req` does not rise for it.
- R7: When several events are pending, `gnt_valid` is high and `gnt_chan` names the lowest pending channel.
- R8: When `gnt_take` is high while `gnt_valid` is high, the granted channel's event bit clears and its secondary bit sets. The secondary bits read back at offset 13.
- R9: Writing ones to event-clear (offset 12), secondary-clear (offset 14) or missed-clear (offset 16) clears those bits. Zeros leave them alone. The event bits read back at offset 11.
- R10: After reset, all maps, enables, events, secondary bits and missed bits are zero, and `gnt_valid` is low.
- R11: When several enabled channels map to the same word, one write to that word raises all of their events in the same cycle.
- R12: Register reads return their data on `cfg_rdata` one cycle after `cfg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | Register write word offset |
| cfg_wdata | input | 14 | Register write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_addr | input | 5 | Register read word offset |
| cfg_rdata | output | 14 | Registered read data |
| pm_wr_en | input | 1 | Parameter-memory write strobe being watched |
| pm_wr_addr | input | 14 | Parameter-memory byte address being watched |
| evt_req | output | 8 | Pending event per channel |
| gnt_valid | output | 1 | At least one event is pending |
| gnt_chan | output | 3 | Lowest pending channel |
| gnt_take | input | 1 | Engine accepts the current grant |

## Verification
The assertions assume that reset is applied before any traffic, and that `gnt_take` is only meaningful while `gnt_valid` is high. They also assume at most one register write per cycle, so a set and a clear of the same bit never arrive together. The stimulus follows these rules. It issues each register write, memory write and take in its own cycle. It raises `gnt_take` only after it has seen a grant. It holds reset for several cycles at the start.

// File: rtl/qdma_trig_pkg.sv
package qdma_trig_pkg;

  typedef enum logic [3:0] {
    RK_MAP      = 4'd0,
    RK_ENA      = 4'd1,
    RK_ENA_SET  = 4'd2,
    RK_ENA_CLR  = 4'd3,
    RK_EVT      = 4'd4,
    RK_EVT_CLR  = 4'd5,
    RK_SEC      = 4'd6,
    RK_SEC_CLR  = 4'd7,
    RK_MISS     = 4'd8,
    RK_MISS_CLR = 4'd9,
    RK_NONE     = 4'd10
  } reg_kind_e;

  localparam int unsigned NUM_CTRL_REGS = 9;

  // Map registers occupy offsets 0..n-1; the control registers follow in enum order.
  function automatic reg_kind_e reg_kind(input int unsigned a, input int unsigned n);
    if (a < n)
      return RK_MAP;
    else if (a - n < NUM_CTRL_REGS)
      return reg_kind_e'(4'(a - n + 1));
    else
      return RK_NONE;
  endfunction

endpackage

// File: rtl/qdma_map_match.sv
module qdma_map_match #(
  parameter int NUM_CH = 8,
  parameter int SET_W  = 9,
  parameter int WORD_W = 3,
  localparam int MAP_W = SET_W + WORD_W,
  localparam int PM_AW = MAP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] map_we,
  input  logic [MAP_W-1:0]  map_wdata,
  input  logic              pm_wr_en,
  input  logic [PM_AW-1:0]  pm_wr_addr,
  output logic [NUM_CH-1:0] hit,
  output logic [MAP_W-1:0]  map_q [NUM_CH]
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        map_q[i] <= '0;
      else if (map_we[i])
        map_q[i] <= map_wdata;
    end

    // Byte address of the trigger word: set*32 + word*4.
    assign hit[i] = pm_wr_en && (pm_wr_addr == {map_q[i], 2'b00});
  end

endmodule

// File: rtl/qdma_chan_state.sv
module qdma_chan_state #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] ena_set,
  input  logic [NUM_CH-1:0] ena_clr,
  input  logic [NUM_CH-1:0] evt_clr,
  input  logic [NUM_CH-1:0] sec_clr,
  input  logic [NUM_CH-1:0] miss_clr,
  input  logic [NUM_CH-1:0] accept,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] evt_q,
  output logic [NUM_CH-1:0] sec_q,
  output logic [NUM_CH-1:0] miss_q
);

  logic [NUM_CH-1:0] trig;
  logic [NUM_CH-1:0] busy;

  assign trig = hit & en_q;
  assign busy = evt_q | sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      evt_q  <= '0;
      sec_q  <= '0;
      miss_q <= '0;
    end else begin
      en_q   <= (en_q | ena_set) & ~ena_clr;
      evt_q  <= (evt_q & ~accept & ~evt_clr) | (trig & ~busy);
      sec_q  <= (sec_q & ~sec_clr) | accept;
      miss_q <= (miss_q & ~miss_clr) | (trig & busy);
    end
  end

endmodule

// File: rtl/qdma_prio_arb.sv
module qdma_prio_arb #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic              take,
  output logic              gnt_valid,
  output logic [CH_W-1:0]   gnt_chan,
  output logic [NUM_CH-1:0] accept
);

  always_comb begin
    gnt_chan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) gnt_chan = CH_W'(i);
    end
  end

  assign gnt_valid = |req;
  assign accept    = (take && gnt_valid) ? (NUM_CH'(1) << gnt_chan) : '0;

endmodule

// File: rtl/qdma_trig_unit.sv
module qdma_trig_unit
  import qdma_trig_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int SET_W   = 9,
  parameter int WORD_W  = 3,
  localparam int MAP_W  = SET_W + WORD_W,
  localparam int DATA_W = MAP_W + 2,
  localparam int PM_AW  = MAP_W + 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int CFG_AW = $clog2(NUM_CH + NUM_CTRL_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rd_en,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              pm_wr_en,
  input  logic [PM_AW-1:0]  pm_wr_addr,
  output logic [NUM_CH-1:0] evt_req,
  output logic              gnt_valid,
  output logic [CH_W-1:0]   gnt_chan,
  input  logic              gnt_take
);

  reg_kind_e wr_kind, rd_kind;
  logic [NUM_CH-1:0] map_we, hit, accept;
  logic [NUM_CH-1:0] ena_set, ena_clr, evt_clr, sec_clr, miss_clr;
  logic [NUM_CH-1:0] en_w, sec_w, miss_w;
  logic [MAP_W-1:0]  map_q [NUM_CH];
  logic [NUM_CH-1:0] wbits;

  assign wr_kind = reg_kind(32'(cfg_wr_addr), NUM_CH);
  assign rd_kind = reg_kind(32'(cfg_rd_addr), NUM_CH);
  assign wbits   = cfg_wdata[NUM_CH-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign map_we[i] = cfg_wr_en && (wr_kind == RK_MAP) && (cfg_wr_addr == CFG_AW'(i));
  end

  assign ena_set  = (cfg_wr_en && wr_kind == RK_ENA_SET)  ? wbits : '0;
  assign ena_clr  = (cfg_wr_en && wr_kind == RK_ENA_CLR)  ? wbits : '0;
  assign evt_clr  = (cfg_wr_en && wr_kind == RK_EVT_CLR)  ? wbits : '0;
  assign sec_clr  = (cfg_wr_en && wr_kind == RK_SEC_CLR)  ? wbits : '0;
  assign miss_clr = (cfg_wr_en && wr_kind == RK_MISS_CLR) ? wbits : '0;

  qdma_map_match #(.NUM_CH(NUM_CH), .SET_W(SET_W), .WORD_W(WORD_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .map_we     (map_we),
    .map_wdata  (cfg_wdata[DATA_W-1:2]),
    .pm_wr_en   (pm_wr_en),
    .pm_wr_addr (pm_wr_addr),
    .hit        (hit),
    .map_q      (map_q)
  );

  qdma_chan_state #(.NUM_CH(NUM_CH)) u_state (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .ena_set  (ena_set),
    .ena_clr  (ena_clr),
    .evt_clr  (evt_clr),
    .sec_clr  (sec_clr),
    .miss_clr (miss_clr),
    .accept   (accept),
    .en_q     (en_w),
    .evt_q    (evt_req),
    .sec_q    (sec_w),
    .miss_q   (miss_w)
  );

  qdma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req       (evt_req),
    .take      (gnt_take),
    .gnt_valid (gnt_valid),
    .gnt_chan  (gnt_chan),
    .accept    (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd_en) begin
      case (rd_kind)
        RK_MAP:  cfg_rdata <= {map_q[cfg_rd_addr[CH_W-1:0]], 2'b00};
        RK_ENA:  cfg_rdata <= DATA_W'(en_w);
        RK_EVT:  cfg_rdata <= DATA_W'(evt_req);
        RK_SEC:  cfg_rdata <= DATA_W'(sec_w);
        RK_MISS: cfg_rdata <= DATA_W'(miss_w);
        default: cfg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/qdma_trig_unit_chk.sv
module qdma_trig_unit_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              pm_wr_en,
  input logic [NUM_CH-1:0] evt_req,
  input logic              gnt_valid,
  input logic [CH_W-1:0]   gnt_chan,
  input logic              gnt_take,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] sec_q,
  input logic [NUM_CH-1:0] miss_q
);

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (evt_req == '0 && en_q == '0 && sec_q == '0 && miss_q == '0));

  p_evt_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    ((evt_req & ~$past(evt_req) & ~$past(en_q)) == '0));

  p_evt_needs_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (|(evt_req & ~$past(evt_req))) |-> $past(pm_wr_en));

  p_miss_needs_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (|(miss_q & ~$past(miss_q))) |-> $past(pm_wr_en));

  p_gnt_lowest_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (evt_req[gnt_chan] &&
                   ((evt_req & ((NUM_CH'(1) << gnt_chan) - NUM_CH'(1))) == '0)));

  p_take_to_sec_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && gnt_take) |=> sec_q[$past(gnt_chan)]);

  p_take_drops_evt_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && gnt_take) |=> !evt_req[$past(gnt_chan)]);

endmodule

bind qdma_trig_unit qdma_trig_unit_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pm_wr_en  (pm_wr_en),
  .evt_req   (evt_req),
  .gnt_valid (gnt_valid),
  .gnt_chan  (gnt_chan),
  .gnt_take  (gnt_take),
  .en_q      (en_w),
  .sec_q     (sec_w),
  .miss_q    (miss_w)
);

// File: tb/qdma_trig_unit_tb_top.sv
module qdma_trig_unit_tb_top;

  localparam int OFS_ENA      = 8;
  localparam int OFS_ENA_SET  = 9;
  localparam int OFS_ENA_CLR  = 10;
  localparam int OFS_EVT      = 11;
  localparam int OFS_EVT_CLR  = 12;
  localparam int OFS_SEC      = 13;
  localparam int OFS_SEC_CLR  = 14;
  localparam int OFS_MISS     = 15;
  localparam int OFS_MISS_CLR = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [13:0] cfg_wdata = '0;
  logic        cfg_rd_en = 1'b0;
  logic [4:0]  cfg_rd_addr = '0;
  logic [13:0] cfg_rdata;
  logic        pm_wr_en = 1'b0;
  logic [13:0] pm_wr_addr = '0;
  logic [7:0]  evt_req;
  logic        gnt_valid;
  logic [2:0]  gnt_chan;
  logic        gnt_take = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  qdma_trig_unit dut_i (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wdata(cfg_wdata),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
    .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr),
    .evt_req(evt_req), .gnt_valid(gnt_valid), .gnt_chan(gnt_chan),
    .gnt_take(gnt_take)
  );

  // Monitor: a read issued before a posedge is compared at the following negedge (R12).
  always @(posedge clk) rd_seen <= cfg_rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [13:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (cfg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s (R12 read): got %h expected %h", t, cfg_rdata, e);
      end
    end
  end

  task automatic cfg_write(input int addr, input logic [13:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pm_write(input logic [13:0] addr, input logic strobe);
    @(negedge clk);
    pm_wr_en = strobe; pm_wr_addr = addr;
    @(negedge clk);
    pm_wr_en = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    gnt_take = 1'b1;
    @(negedge clk);
    gnt_take = 1'b0;
  endtask

  task automatic expect_rd(input int addr, input logic [13:0] e, input string t);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_rd_addr = 5'(addr);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    cfg_rd_en = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(32'(evt_req), 0, "R10 evt_req after reset");
    chk(32'(gnt_valid), 0, "R10 gnt_valid after reset");
    expect_rd(0, 14'h0, "R10 map0");
    expect_rd(OFS_ENA, 14'h0, "R10 enable");
    expect_rd(OFS_MISS, 14'h0, "R10 missed");
    expect_rd(OFS_SEC, 14'h0, "R10 secondary");

    // R1 map layout: set 5 word 7 -> 0x0BC; junk in bits 1:0 dropped
    cfg_write(0, 14'h0BC);
    cfg_write(1, 14'h006B);            // set 3 word 2 plus bits 1:0 set
    expect_rd(0, 14'h0BC, "R1 map0");
    expect_rd(1, 14'h068, "R1 map1 low bits zero");

    // R3 disabled channel ignores matching write (byte 188)
    pm_write(14'd188, 1'b1);
    @(negedge clk);
    chk(32'(evt_req), 0, "R3 disabled channel");

    // R4 enable set/clear
    cfg_write(OFS_ENA_SET, 14'h03);
    expect_rd(OFS_ENA, 14'h03, "R4 set");
    cfg_write(OFS_ENA_SET, 14'h00);
    cfg_write(OFS_ENA_CLR, 14'h00);
    expect_rd(OFS_ENA, 14'h03, "R4 zeros no effect");
    cfg_write(OFS_ENA_CLR, 14'h02);
    expect_rd(OFS_ENA, 14'h01, "R4 clear");
    cfg_write(OFS_ENA_SET, 14'h02);

    // R5 near misses
    pm_write(14'd184, 1'b1);
    pm_write(14'd220, 1'b1);
    pm_write(14'd188, 1'b0);
    chk(32'(evt_req), 0, "R5 near misses");

    // R2 trigger
    pm_write(14'd188, 1'b1);
    chk(32'(evt_req), 32'h01, "R2 event raised");
    chk(32'(gnt_valid), 1, "R2 grant valid");
    chk(32'(gnt_chan), 0, "R7 single grant chan");

    // R6 while event pending
    pm_write(14'd188, 1'b1);
    chk(32'(evt_req), 32'h01, "R6 event unchanged");
    expect_rd(OFS_MISS, 14'h01, "R6 missed on pending event");

    // R8 take
    take();
    chk(32'(evt_req), 0, "R8 event cleared by take");
    expect_rd(OFS_SEC, 14'h01, "R8 secondary set");

    // R9 missed clear
    cfg_write(OFS_MISS_CLR, 14'h00);
    expect_rd(OFS_MISS, 14'h01, "R9 missed zero no effect");
    cfg_write(OFS_MISS_CLR, 14'h01);
    expect_rd(OFS_MISS, 14'h00, "R9 missed cleared");

    // R6 while secondary pending
    pm_write(14'd188, 1'b1);
    chk(32'(evt_req), 0, "R6 not queued on secondary");
    expect_rd(OFS_MISS, 14'h01, "R6 missed on secondary");
    cfg_write(OFS_SEC_CLR, 14'h01);
    expect_rd(OFS_SEC, 14'h00, "R9 secondary cleared");
    cfg_write(OFS_MISS_CLR, 14'h01);

    // R9 event clear
    pm_write(14'd188, 1'b1);
    chk(32'(evt_req), 32'h01, "R2 retrigger");
    expect_rd(OFS_EVT, 14'h01, "R9 event readback");
    cfg_write(OFS_EVT_CLR, 14'h01);
    chk(32'(evt_req), 0, "R9 event cleared");

    // R11 shared word, R7 priority
    cfg_write(2, 14'h068);
    cfg_write(OFS_ENA_SET, 14'h06);
    pm_write(14'd104, 1'b1);
    chk(32'(evt_req), 32'h06, "R11 two channels together");
    chk(32'(gnt_chan), 1, "R7 lowest first");
    take();
    chk(32'(gnt_chan), 2, "R7 next grant");
    take();
    chk(32'(gnt_valid), 0, "R8 all taken");
    expect_rd(OFS_SEC, 14'h06, "R8 secondary bits");

    // largest set number 511, word 0
    cfg_write(4, 14'h3FE0);
    cfg_write(7, 14'h3FE0);
    cfg_write(OFS_ENA_SET, 14'h90);
    pm_write(14'h3FE0, 1'b1);
    chk(32'(evt_req), 32'h90, "R11 max set");
    chk(32'(gnt_chan), 4, "R7 ch4 before ch7");
    take();
    chk(32'(gnt_chan), 7, "R7 ch7 after take");
    cfg_write(OFS_EVT_CLR, 14'h00);
    chk(32'(evt_req), 32'h80, "R9 event zero no effect");
    cfg_write(OFS_EVT_CLR, 14'h80);
    chk(32'(gnt_valid), 0, "R9 event clear drops grant");
    expect_rd(OFS_SEC, 14'h16, "R8 secondary accumulates");
    cfg_write(OFS_SEC_CLR, 14'h00);
    expect_rd(OFS_SEC, 14'h16, "R9 secondary zero no effect");
    cfg_write(OFS_SEC_CLR, 14'h06);
    expect_rd(OFS_SEC, 14'h10, "R9 secondary partial clear");

    // stop channel 0
    cfg_write(OFS_ENA_CLR, 14'h01);
    cfg_write(OFS_SEC_CLR, 14'h01);
    cfg_write(OFS_MISS_CLR, 14'h01);
    cfg_write(0, 14'h0);
    expect_rd(0, 14'h0, "R1 map0 zeroed");
    expect_rd(OFS_ENA, 14'h96, "R4 after stop");
    pm_write(14'd188, 1'b1);
    pm_write(14'd0, 1'b1);
    chk(32'(evt_req), 0, "R3 stopped channel silent");
    expect_rd(OFS_MISS, 14'h00, "R6 no missed after stop");

    finish_run();
  end

endmodule